// File: doc/BRIEF.md
# Embedded-Clock Frame Serializer

This block turns a parallel payload word into a continuous serial stream in which every word travels inside an 18-bit frame. The frame begins with a clock bit that is always high and ends with a clock bit that is always low. Because of this, a receiver sees a low-to-high edge at a fixed position in every word, whatever the payload holds. Everything runs on one bit-rate clock. A single-cycle word strobe marks each word and takes the place of the parallel word clock. When the strobes come exactly one frame period apart, the frames follow each other with no idle bit times between them.

Three controls change the normal flow:

- **Sync request.** The payload is replaced by a fixed training pattern, and the two clock bits still frame it.
- **Power-down (active-low).** The transmitter is switched off.
- **Local loopback.** The serial line is turned off, and each captured word is handed to a parallel loopback port instead. A receive side can then check the word without using the line.

Top module: `ecf_serializer`

## Requirements
- R1: A strobe that is accepted starts a frame. In the first bit time after the strobe edge, `ser_o` is 1. In the next 16 bit times it carries the captured word with bit 0 first. In the 18th bit time it is 0.
- R2: A strobe is accepted only when the line is idle or when the current frame is in its 18th bit time. A strobe that arrives at any other point in a frame is ignored, and the frame in flight continues unchanged.
- R3: Strobes spaced exactly 18 cycles apart give gap-free frames. Each low clock bit is followed directly by the high clock bit of the next frame.
- R4: When `sync_req_i` is high at an accepted strobe, the payload sent is eight ones followed by eight zeros. This is word value 16'h00FF sent bit 0 first, and it is still framed by the high and low clock bits.
- R5: After reset, and after any frame that is not followed by an accepted strobe, `ser_o` stays 0. While powered and not in loopback, `ser_oe_o` is 1.
- R6: While `tx_pd_ni` is 0:
  - `ser_oe_o` and `ser_o` are 0.
  - Any frame in flight is abandoned.
  - Strobes are ignored, and `loop_vld_o` stays 0.
  - After `tx_pd_ni` returns to 1, the line stays 0 until the next strobe.
- R7: While `loop_en_i` is 1 (and powered), the following hold:
  - `ser_oe_o` and `ser_o` are 0, and the serial frame engine is idle.
  - Every strobe copies the word (with the sync substitution of R4 applied) to `loop_data_o`.
  - `loop_vld_o` is 1 for exactly the cycle after that strobe edge.
  - `loop_data_o` holds its value between strobes.
- R8: `loop_vld_o` is never 1 unless loopback was enabled with power on at the preceding strobe edge.
- R9: During reset, `ser_o`, `loop_vld_o` and `loop_data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| word_stb_i | input | 1 | One-cycle word strobe |
| payload_i | input | 16 | Parallel payload word |
| sync_req_i | input | 1 | Replace payload by training pattern |
| tx_pd_ni | input | 1 | Active-low transmitter power-down |
| loop_en_i | input | 1 | Local loopback enable |
| ser_o | output | 1 | Serial line data |
| ser_oe_o | output | 1 | Serial line output enable |
| loop_data_o | output | 16 | Word delivered on the loopback port |
| loop_vld_o | output | 1 | Loopback word valid, one cycle per strobe |

## Verification
Some properties are checked by assertions on every cycle:

- Each frame opens with a high bit and closes with a low bit.
- The bit counter advances by one in mid-frame, whatever the strobe does.
- The line is low whenever no frame is active.
- The frame engine is idle after power-down or loopback.
- A loopback-valid pulse is always traceable to a loopback strobe.

Other behaviour can only be shown by the bench scenarios, where the reference model follows every bit of the line:

- the payload order and the sync pattern content;
- back-to-back framing;
- the rejection of mid-frame strobes with differing words;
- recovery after power-down;
- the loopback data values.

// File: rtl/ecf_pkg.sv
package ecf_pkg;

  typedef enum logic [1:0] {
    MODE_OFF  = 2'd0,
    MODE_LOOP = 2'd1,
    MODE_LINE = 2'd2
  } ecf_mode_e;

  function automatic ecf_mode_e mode_of(input logic pd_n, input logic loop_en);
    ecf_mode_e m;
    if (!pd_n)        m = MODE_OFF;
    else if (loop_en) m = MODE_LOOP;
    else              m = MODE_LINE;
    return m;
  endfunction

endpackage

// File: rtl/ecf_rst_sync.sv
module ecf_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/ecf_word_sel.sv
module ecf_word_sel #(
  parameter int PAYLOAD_W = 16,
  localparam int FRAME_W  = PAYLOAD_W + 2
) (
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic                 sync_i,
  output logic [PAYLOAD_W-1:0] word_o,
  output logic [FRAME_W-1:0]   frame_o
);
  logic [PAYLOAD_W-1:0] train_pat;

  // training pattern: lower half ones, upper half zeros (ones leave first)
  for (genvar i = 0; i < PAYLOAD_W; i++) begin : g_pat
    if (i < PAYLOAD_W / 2) begin : g_one
      assign train_pat[i] = 1'b1;
    end else begin : g_zero
      assign train_pat[i] = 1'b0;
    end
  end

  always_comb begin
    word_o  = sync_i ? train_pat : payload_i;
    // bit 0 leaves first: high clock bit, payload LSB..MSB, low clock bit
    frame_o = {1'b0, word_o, 1'b1};
  end
endmodule

// File: rtl/ecf_bit_timer.sv
module ecf_bit_timer
  import ecf_pkg::*;
#(
  parameter int FRAME_W  = 18,
  localparam int CNT_W   = $clog2(FRAME_W),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ecf_mode_e        mode_i,
  input  logic             stb_i,
  output logic             load_o,
  output logic             clr_o,
  output logic             busy_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic             busy_q, busy_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             at_last;

  assign at_last = busy_q && (cnt_q == LAST);
  assign clr_o   = (mode_i != MODE_LINE);
  assign load_o  = (mode_i == MODE_LINE) && stb_i && (!busy_q || at_last);

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (clr_o) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (load_o) begin
      busy_d = 1'b1;
      cnt_d  = '0;
    end else if (at_last) begin
      busy_d = 1'b0;
      cnt_d  = '0;
    end else if (busy_q) begin
      cnt_d  = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/ecf_frame_shift.sv
module ecf_frame_shift #(
  parameter int FRAME_W = 18
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               load_i,
  input  logic               shift_en_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic               bit_o
);
  logic [FRAME_W-1:0] sreg_q, sreg_d;
  logic               upd;

  assign upd = clr_i || load_i || shift_en_i;

  always_comb begin
    sreg_d = sreg_q;
    if (clr_i)           sreg_d = '0;
    else if (load_i)     sreg_d = frame_i;
    else if (shift_en_i) sreg_d = {1'b0, sreg_q[FRAME_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)  sreg_q <= '0;
    else if (upd) sreg_q <= sreg_d;
  end

  assign bit_o = sreg_q[0];
endmodule

// File: rtl/ecf_loop_port.sv
module ecf_loop_port #(
  parameter int PAYLOAD_W = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cap_i,
  input  logic [PAYLOAD_W-1:0] word_i,
  output logic [PAYLOAD_W-1:0] data_o,
  output logic                 vld_o
);
  logic [PAYLOAD_W-1:0] data_q;
  logic                 vld_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    data_q <= '0;
    else if (cap_i) data_q <= word_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) vld_q <= 1'b0;
    else         vld_q <= cap_i;
  end

  assign data_o = data_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/ecf_serializer.sv
module ecf_serializer
  import ecf_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  localparam int FRAME_W  = PAYLOAD_W + 2,
  localparam int CNT_W    = $clog2(FRAME_W)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 word_stb_i,
  input  logic [PAYLOAD_W-1:0] payload_i,
  input  logic                 sync_req_i,
  input  logic                 tx_pd_ni,
  input  logic                 loop_en_i,
  output logic                 ser_o,
  output logic                 ser_oe_o,
  output logic [PAYLOAD_W-1:0] loop_data_o,
  output logic                 loop_vld_o
);
  logic                 rst_sync_n;
  ecf_mode_e            mode;
  logic [PAYLOAD_W-1:0] sel_word;
  logic [FRAME_W-1:0]   sel_frame;
  logic                 ld, clr, busy, line_bit, loop_cap;
  logic [CNT_W-1:0]     bit_cnt;

  ecf_rst_sync #(.STAGES(2)) u_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_sync_no(rst_sync_n)
  );

  assign mode = mode_of(tx_pd_ni, loop_en_i);

  ecf_word_sel #(.PAYLOAD_W(PAYLOAD_W)) u_sel (
    .payload_i(payload_i), .sync_i(sync_req_i),
    .word_o(sel_word), .frame_o(sel_frame)
  );

  ecf_bit_timer #(.FRAME_W(FRAME_W)) u_tmr (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .mode_i(mode), .stb_i(word_stb_i),
    .load_o(ld), .clr_o(clr), .busy_o(busy), .cnt_o(bit_cnt)
  );

  ecf_frame_shift #(.FRAME_W(FRAME_W)) u_shf (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .clr_i(clr), .load_i(ld),
    .shift_en_i(busy), .frame_i(sel_frame), .bit_o(line_bit)
  );

  assign loop_cap = (mode == MODE_LOOP) && word_stb_i;

  ecf_loop_port #(.PAYLOAD_W(PAYLOAD_W)) u_lpb (
    .clk_i(clk_i), .rst_ni(rst_sync_n), .cap_i(loop_cap),
    .word_i(sel_word), .data_o(loop_data_o), .vld_o(loop_vld_o)
  );

  assign ser_oe_o = (mode == MODE_LINE);
  assign ser_o    = line_bit & ser_oe_o;
endmodule

// File: rtl/ecf_serializer_chk.sv
module ecf_serializer_chk #(
  parameter int FRAME_W = 18,
  localparam int CNT_W  = $clog2(FRAME_W),
  localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_W - 1)
) (
  input logic             clk_i,
  input logic             rst_n,
  input logic             stb,
  input logic             pd_n,
  input logic             loop_en,
  input logic             ser,
  input logic             oe,
  input logic             lvld,
  input logic             busy,
  input logic [CNT_W-1:0] cnt
);
  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    cnt <= LAST); // R1

  AST_FRAME_OPENS_HIGH: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && cnt == '0 && oe) |-> ser); // R1

  AST_FRAME_CLOSES_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && cnt == LAST && oe) |-> !ser); // R3

  AST_MIDFRAME_ADVANCE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (busy && cnt != LAST && pd_n && !loop_en) |=> (busy && cnt == $past(cnt) + CNT_W'(1))); // R2

  AST_IDLE_LINE_LOW: assert property (@(posedge clk_i) disable iff (!rst_n)
    !busy |-> !ser); // R5

  AST_OFF_STOPS_FRAME: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!pd_n || loop_en) |=> !busy); // R6

  AST_LOOP_VLD_SOURCE: assert property (@(posedge clk_i) disable iff (!rst_n)
    lvld |-> $past(loop_en && pd_n && stb)); // R8

  AST_LOOP_VLD_SET: assert property (@(posedge clk_i) disable iff (!rst_n)
    (loop_en && pd_n && stb) |=> lvld); // R7
endmodule

bind ecf_serializer ecf_serializer_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk_i(clk_i), .rst_n(rst_sync_n), .stb(word_stb_i), .pd_n(tx_pd_ni),
  .loop_en(loop_en_i), .ser(ser_o), .oe(ser_oe_o), .lvld(loop_vld_o),
  .busy(busy), .cnt(bit_cnt)
);

// File: tb/ecf_serializer_tb.sv
module ecf_serializer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        stb = 1'b0;
  logic [15:0] word = '0;
  logic        sync = 1'b0;
  logic        pd_n = 1'b1;
  logic        lp = 1'b0;
  logic        ser, oe, lvld;
  logic [15:0] ldata;

  int    n_vec = 0;
  int    n_bad = 0;
  bit    done = 1'b0;
  string cur_req = "R9";

  // reference model state
  bit          mq[$];
  logic [15:0] m_ldata = '0;
  logic        m_lvld = 1'b0;

  always #5 clk = ~clk;

  ecf_serializer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .word_stb_i(stb), .payload_i(word),
    .sync_req_i(sync), .tx_pd_ni(pd_n), .loop_en_i(lp),
    .ser_o(ser), .ser_oe_o(oe), .loop_data_o(ldata), .loop_vld_o(lvld)
  );

  function automatic logic [15:0] eff_word(input logic [15:0] w, input logic s);
    return s ? 16'h00FF : w;
  endfunction

  always @(posedge clk) begin
    logic exp_oe, exp_ser;
    if (!rst_n) begin
      mq.delete();
      m_ldata = '0;
      m_lvld  = 1'b0;
    end else begin
      m_lvld = 1'b0;
      if (!pd_n) begin
        mq.delete();
      end else if (lp) begin
        mq.delete();
        if (stb) begin
          m_ldata = eff_word(word, sync);
          m_lvld  = 1'b1;
        end
      end else if (stb && mq.size() <= 1) begin
        logic [15:0] w;
        w = eff_word(word, sync);
        mq.delete();
        mq.push_back(1'b1);
        for (int i = 0; i < 16; i++) mq.push_back(w[i]);
        mq.push_back(1'b0);
      end else if (mq.size() > 0) begin
        void'(mq.pop_front());
      end
    end
    #2;
    exp_oe  = pd_n && !lp;
    exp_ser = (mq.size() > 0) ? (mq[0] & exp_oe) : 1'b0;
    n_vec++;
    if (oe !== exp_oe) begin
      n_bad++;
      $display("FAIL %s ser_oe_o got %b exp %b at %0t", cur_req, oe, exp_oe, $time);
    end
    if (ser !== exp_ser) begin
      n_bad++;
      $display("FAIL %s ser_o got %b exp %b at %0t", cur_req, ser, exp_ser, $time);
    end
    if (lvld !== m_lvld) begin
      n_bad++;
      $display("FAIL %s loop_vld_o got %b exp %b at %0t", cur_req, lvld, m_lvld, $time);
    end
    if (ldata !== m_ldata) begin
      n_bad++;
      $display("FAIL %s loop_data_o got %h exp %h at %0t", cur_req, ldata, m_ldata, $time);
    end
  end

  task automatic cyc(input logic s, input logic [15:0] w, input logic sy);
    @(negedge clk);
    stb = s; word = w; sync = sy;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 16'h0000, 1'b0);
  endtask

  // one strobe then n-1 idle cycles (frame period when n == 18)
  task automatic send(input logic [15:0] w, input logic sy, input int n);
    cyc(1'b1, w, sy);
    idle(n - 1);
  endtask

  initial begin
    // R9: outputs during reset
    cur_req = "R9";
    idle(4);
    @(negedge clk); rst_n = 1'b1;
    // R5: idle line low after reset, until the first strobe
    cur_req = "R5";
    idle(8);
    // R1: single frame, then line returns low
    cur_req = "R1";
    send(16'hA5C3, 1'b0, 18);
    cur_req = "R5";
    idle(6);
    // R3: back-to-back frames at an 18-cycle spacing
    cur_req = "R3";
    send(16'hFFFF, 1'b0, 18);
    send(16'h0000, 1'b0, 18);
    send(16'h8001, 1'b0, 18);
    send(16'h7FFE, 1'b0, 18);
    idle(3);
    // R2: strobes mid-frame carry other words and must be ignored
    cur_req = "R2";
    send(16'h1234, 1'b0, 5);
    send(16'hDEAD, 1'b0, 6);
    send(16'hBEEF, 1'b0, 7);
    send(16'h5A5A, 1'b0, 18);
    idle(4);
    // R4: sync request forces the training payload
    cur_req = "R4";
    send(16'hC0DE, 1'b1, 18);
    send(16'h3C3C, 1'b1, 18);
    send(16'h0F0F, 1'b0, 20);
    // R6: power-down mid-frame, strobes while down, recovery
    cur_req = "R6";
    send(16'h9669, 1'b0, 7);
    pd_n = 1'b0;
    idle(2);
    send(16'hFACE, 1'b0, 3);
    send(16'h1111, 1'b0, 3);
    pd_n = 1'b1;
    idle(6);
    send(16'h2468, 1'b0, 20);
    // R7: local loopback, including sync substitution
    cur_req = "R7";
    send(16'h4321, 1'b0, 8);
    lp = 1'b1;
    idle(2);
    send(16'hABCD, 1'b0, 3);
    send(16'h1357, 1'b1, 2);
    cyc(1'b1, 16'hEEEE, 1'b0);
    cyc(1'b1, 16'h0101, 1'b0);
    idle(4);
    // R8: powered down inside loopback gives no valid pulse
    cur_req = "R8";
    pd_n = 1'b0;
    send(16'h7777, 1'b0, 4);
    pd_n = 1'b1;
    lp = 1'b0;
    idle(3);
    send(16'hCAFE, 1'b0, 22);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete (got timeout, exp completion)");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule